// File: doc/BRIEF.md
# Byte/Word ALU with Flag Generation

This block is the arithmetic and logic stage of a small 8/16-bit microcontroller datapath. On each cycle where the operation strobe is high it takes an already fetched destination and source operand, applies one of eight operations (add, add with carry, subtract, subtract with borrow, compare, AND, OR, XOR) at byte or word width, registers the truncated result together with a write-enable, and updates a status byte that holds carry, auxiliary-carry and zero flags.

Flags are not derived from adder carry chains. Each flag comes from comparing the width-extended result with the old destination value: a toggled bit just above the operand width gives carry, a toggled half-width boundary bit together with a numerically smaller low half gives auxiliary carry, and an all-zero truncated result gives zero. A three-bit mask supplied with every operation chooses which flags may change. The carry used by add-with-carry and subtract-with-borrow is the block's own stored carry flag.

Top module: `alu_flag_unit`

## Requirements
- R1: Operation code 0 adds source to destination and code 1 additionally adds the stored carry flag; the result is truncated to the selected width (8 bits when wordMode is 0, 16 bits when 1), so operand bits above the width have no effect and result bits 15..8 are 0 in byte mode.
- R2: Operation code 2 computes destination minus source and code 3 computes destination minus source minus the stored carry flag, truncated to the selected width.
- R3: Operation code 4 (compare) evaluates destination minus source for the flags only: resultWe stays low and result keeps its previous value.
- R4: Operation codes 5, 6 and 7 produce the bitwise AND, OR and XOR of the two operands.
- R5: When selected, the carry flag (statusByte bit 0) is set exactly when bit 8 (byte) or bit 16 (word) of the unmasked result differs from that bit of the zero-extended old destination.
- R6: When selected, the auxiliary-carry flag (statusByte bit 4) is set exactly when bit 4 (byte) or bit 8 (word) differs between unmasked result and old destination and the low 4 (byte) or 8 (word) result bits are numerically smaller than those of the old destination.
- R7: When selected, the zero flag (statusByte bit 6) is set exactly when the width-truncated result is zero.
- R8: flagMask bit 0 selects carry, bit 1 auxiliary carry and bit 2 zero; a selected flag is recomputed, an unselected flag keeps its value; all other statusByte bits are 0.
- R9: With opValid low the status byte and result keep their values and resultWe is low in the following cycle; with opValid high the result, resultWe and status byte take their new values at that clock edge.
- R10: After reset the status byte, result and resultWe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe for this cycle |
| opCode | input | 3 | Operation select (0 add .. 7 XOR) |
| wordMode | input | 1 | 1 selects 16-bit operands, 0 selects 8-bit |
| dstVal | input | WORD_W | Destination operand (old value) |
| srcVal | input | WORD_W | Source operand |
| flagMask | input | 3 | Flags allowed to change: bit0 carry, bit1 aux, bit2 zero |
| result | output | WORD_W | Registered, width-truncated result |
| resultWe | output | 1 | Registered write-enable for the result |
| statusByte | output | 8 | Status register: bit0 carry, bit4 aux carry, bit6 zero |

## Verification
The hardest situation to reach is one where an unselected flag must survive an operation that would otherwise have changed it, because it needs a prior operation to leave that flag in a known non-default state. The stimulus therefore chains operations: a byte add of 0xFF and 0x01 first sets all three flags, later a word add across the low-byte boundary sets auxiliary carry alone, and masked logic and add operations follow that would have cleared or set the held flags. Borrow chains feed the stored carry into subtract-with-borrow and add-with-carry so that both carry-in values are exercised.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  // status byte layout
  localparam int STAT_W   = 8;
  localparam int CY_POS   = 0;
  localparam int AC_POS   = 4;
  localparam int ZF_POS   = 6;

  // flag mask layout
  localparam int MASK_W   = 3;
  localparam int MSK_CY   = 0;
  localparam int MSK_AC   = 1;
  localparam int MSK_ZF   = 2;

  localparam int OPC_W    = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBC = 3'd3,
    OP_CMP  = 3'd4,
    OP_AND  = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } aluOp_t;

  typedef enum logic [1:0] {
    LOG_AND,
    LOG_OR,
    LOG_XOR,
    LOG_NONE
  } logicSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      fire;
    logic      subtract;
    logic      addCarry;
    logic      isLogic;
    logicSel_t logicSel;
    logic      writeBack;
  } aluStrobe_t;

endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  output aluStrobe_t       strb,
  output logic             resultWe
);

  aluOp_t opDec;

  assign opDec = aluOp_t'(opCode);

  always_comb begin
    strb           = '0;
    strb.logicSel  = LOG_NONE;
    strb.fire      = opValid;
    strb.writeBack = 1'b1;
    unique case (opDec)
      OP_ADD:  ;
      OP_ADDC: strb.addCarry = 1'b1;
      OP_SUB:  strb.subtract = 1'b1;
      OP_SUBC: begin
        strb.subtract = 1'b1;
        strb.addCarry = 1'b1;
      end
      OP_CMP: begin
        strb.subtract  = 1'b1;
        strb.writeBack = 1'b0;
      end
      OP_AND: begin
        strb.isLogic  = 1'b1;
        strb.logicSel = LOG_AND;
      end
      OP_OR: begin
        strb.isLogic  = 1'b1;
        strb.logicSel = LOG_OR;
      end
      OP_XOR: begin
        strb.isLogic  = 1'b1;
        strb.logicSel = LOG_XOR;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultWe <= 1'b0;
    end else begin
      resultWe <= opValid & strb.writeBack;
    end
  end

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |=> !resultWe); // R3

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resultWe); // R9

  AST_OP_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode != OP_CMP) |=> resultWe); // R9

endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval #(
  parameter int SIZE_W = 8
) (
  input  logic                   beforeTop,
  input  logic                   beforeMid,
  input  logic [SIZE_W/2-1:0]    beforeLow,
  input  logic [SIZE_W:0]        afterVal,
  output logic                   carryOut,
  output logic                   auxOut,
  output logic                   zeroOut
);

  localparam int HALF_W = SIZE_W / 2;

  always_comb begin
    carryOut = afterVal[SIZE_W] ^ beforeTop;
    auxOut   = (afterVal[HALF_W] ^ beforeMid) &&
               (afterVal[HALF_W-1:0] < beforeLow);
    zeroOut  = (afterVal[SIZE_W-1:0] == '0);
  end

endmodule

// File: rtl/alu_flag_dp.sv
module alu_flag_dp
  import alu_flag_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strb,
  input  logic              wordMode,
  input  logic [WORD_W-1:0] dstVal,
  input  logic [WORD_W-1:0] srcVal,
  input  logic [MASK_W-1:0] flagMask,
  output logic [WORD_W-1:0] result,
  output logic [STAT_W-1:0] statusByte
);

  localparam int BYTE_W = WORD_W / 2;
  localparam int EXT_W  = WORD_W + 1;
  localparam int N_SIZE = 2;

  logic              carryQ, auxQ, zeroQ;
  logic [WORD_W-1:0] resultQ;
  logic [EXT_W-1:0]  dstExt, srcExt, arithExt, logicExt, afterExt;
  logic [EXT_W-1:0]  carryTerm;
  logic [N_SIZE-1:0] cyV, acV, zfV;
  logic              cyNew, acNew, zfNew;
  logic [WORD_W-1:0] truncRes;

  // width selection of operands
  always_comb begin
    if (wordMode) begin
      dstExt = {1'b0, dstVal};
      srcExt = {1'b0, srcVal};
    end else begin
      dstExt = {{(EXT_W-BYTE_W){1'b0}}, dstVal[BYTE_W-1:0]};
      srcExt = {{(EXT_W-BYTE_W){1'b0}}, srcVal[BYTE_W-1:0]};
    end
  end

  assign carryTerm = {{(EXT_W-1){1'b0}}, strb.addCarry & carryQ};

  always_comb begin
    if (strb.subtract) arithExt = dstExt - srcExt - carryTerm;
    else               arithExt = dstExt + srcExt + carryTerm;
  end

  always_comb begin
    unique case (strb.logicSel)
      LOG_AND: logicExt = dstExt & srcExt;
      LOG_OR:  logicExt = dstExt | srcExt;
      LOG_XOR: logicExt = dstExt ^ srcExt;
      default: logicExt = '0;
    endcase
  end

  assign afterExt = strb.isLogic ? logicExt : arithExt;

  // one flag evaluator per operand size
  for (genvar g = 0; g < N_SIZE; g++) begin : g_size
    localparam int SW = (g == 0) ? BYTE_W : WORD_W;
    alu_flag_eval #(.SIZE_W(SW)) u_eval (
      .beforeTop (dstExt[SW]),
      .beforeMid (dstExt[SW/2]),
      .beforeLow (dstExt[SW/2-1:0]),
      .afterVal  (afterExt[SW:0]),
      .carryOut  (cyV[g]),
      .auxOut    (acV[g]),
      .zeroOut   (zfV[g])
    );
  end

  always_comb begin
    cyNew = wordMode ? cyV[1] : cyV[0];
    acNew = wordMode ? acV[1] : acV[0];
    zfNew = wordMode ? zfV[1] : zfV[0];
    if (wordMode) truncRes = afterExt[WORD_W-1:0];
    else          truncRes = {{(WORD_W-BYTE_W){1'b0}}, afterExt[BYTE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryQ  <= 1'b0;
      auxQ    <= 1'b0;
      zeroQ   <= 1'b0;
      resultQ <= '0;
    end else if (strb.fire) begin
      if (flagMask[MSK_CY]) carryQ <= cyNew;
      if (flagMask[MSK_AC]) auxQ   <= acNew;
      if (flagMask[MSK_ZF]) zeroQ  <= zfNew;
      if (strb.writeBack)   resultQ <= truncRes;
    end
  end

  always_comb begin
    statusByte         = '0;
    statusByte[CY_POS] = carryQ;
    statusByte[AC_POS] = auxQ;
    statusByte[ZF_POS] = zeroQ;
  end

  assign result = resultQ;

  AST_STATUS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fire |=> $stable(statusByte)); // R9

  AST_CARRY_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && !flagMask[MSK_CY]) |=> $stable(carryQ)); // R8

  AST_AUX_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && !flagMask[MSK_AC]) |=> $stable(auxQ)); // R8

  AST_ZERO_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && !flagMask[MSK_ZF]) |=> $stable(zeroQ)); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.fire && strb.writeBack) |=> $stable(resultQ)); // R3

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.writeBack && !wordMode) |=> (resultQ[WORD_W-1:BYTE_W] == '0)); // R1

  AST_ZERO_MATCHES_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.writeBack && flagMask[MSK_ZF]) |=> (zeroQ == (resultQ == '0))); // R7

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              wordMode,
  input  logic [WORD_W-1:0] dstVal,
  input  logic [WORD_W-1:0] srcVal,
  input  logic [2:0]        flagMask,
  output logic [WORD_W-1:0] result,
  output logic              resultWe,
  output logic [7:0]        statusByte
);

  aluStrobe_t strb;

  alu_flag_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCode   (opCode),
    .strb     (strb),
    .resultWe (resultWe)
  );

  alu_flag_dp #(.WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wordMode   (wordMode),
    .dstVal     (dstVal),
    .srcVal     (srcVal),
    .flagMask   (flagMask),
    .result     (result),
    .statusByte (statusByte)
  );

endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic        wordMode = 1'b0;
  logic [15:0] dstVal = '0;
  logic [15:0] srcVal = '0;
  logic [2:0]  flagMask = '0;
  logic [15:0] result;
  logic        resultWe;
  logic [7:0]  statusByte;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic [7:0]  st;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  logic        expC = 1'b0, expAC = 1'b0, expZ = 1'b0;
  logic [15:0] expRes = '0;

  always #5 clk = ~clk;

  alu_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .wordMode(wordMode), .dstVal(dstVal), .srcVal(srcVal),
    .flagMask(flagMask), .result(result), .resultWe(resultWe),
    .statusByte(statusByte)
  );

  // driver: one operation per cycle, expected outcome pushed alongside
  task automatic drive(input logic v, input logic [2:0] op, input logic w,
                       input logic [15:0] d, input logic [15:0] s,
                       input logic [2:0] m, input string tag);
    int width, msk, b, a, c, r, hb, lm;
    logic cy, ac, z;
    expItem_t it;
    @(negedge clk);
    opValid = v; opCode = op; wordMode = w;
    dstVal = d; srcVal = s; flagMask = m;
    if (v) begin
      width = w ? 16 : 8;
      msk = (1 << width) - 1;
      b = int'(d) & msk;
      a = int'(s) & msk;
      c = expC ? 1 : 0;
      case (op)
        3'd0: r = b + a;
        3'd1: r = b + a + c;
        3'd2: r = b - a;
        3'd3: r = b - a - c;
        3'd4: r = b - a;
        3'd5: r = b & a;
        3'd6: r = b | a;
        default: r = b ^ a;
      endcase
      hb = width / 2;
      lm = (1 << hb) - 1;
      cy = ((r >> width) & 1) != ((b >> width) & 1);
      ac = (((r >> hb) & 1) != ((b >> hb) & 1)) && ((r & lm) < (b & lm));
      z  = (r & msk) == 0;
      if (m[0]) expC = cy;
      if (m[1]) expAC = ac;
      if (m[2]) expZ = z;
      if (op != 3'd4) expRes = 16'(r & msk);
    end
    it.res = expRes;
    it.we  = v && (op != 3'd4);
    it.st  = {1'b0, expZ, 1'b0, expAC, 3'b000, expC};
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare after the capturing edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (result !== it.res || resultWe !== it.we || statusByte !== it.st) begin
          errors++;
          $display("FAIL %s: result %h exp %h, we %b exp %b, status %h exp %h",
                   it.tag, result, it.res, resultWe, it.we, statusByte, it.st);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung, expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (result !== 16'h0 || resultWe !== 1'b0 || statusByte !== 8'h00) begin
      errors++;
      $display("FAIL R10: result %h we %b status %h, expected 0000 0 00",
               result, resultWe, statusByte);
    end
    @(negedge clk);
    rstN = 1'b1;

    drive(1, 3'd0, 0, 16'h00FF, 16'h0001, 3'b111, "R5 R6 R7 byte add wrap");
    drive(1, 3'd1, 0, 16'h0010, 16'h0005, 3'b111, "R1 addc carry in 1");
    drive(1, 3'd2, 0, 16'h0000, 16'h0001, 3'b111, "R2 byte sub borrow");
    drive(1, 3'd3, 0, 16'h0020, 16'h0005, 3'b111, "R2 subc with borrow");
    drive(1, 3'd4, 1, 16'h1234, 16'h1234, 3'b111, "R3 compare equal");
    drive(1, 3'd0, 1, 16'h8000, 16'h8000, 3'b111, "R5 word carry");
    drive(1, 3'd0, 1, 16'h00FF, 16'h0001, 3'b111, "R6 word aux");
    drive(1, 3'd5, 0, 16'h00F0, 16'h000F, 3'b100, "R4 R8 and zero only");
    drive(1, 3'd6, 1, 16'h1200, 16'h0034, 3'b100, "R4 R8 or word");
    drive(1, 3'd7, 0, 16'h005A, 16'h00FF, 3'b111, "R4 R6 xor byte");
    drive(0, 3'd0, 1, 16'hFFFF, 16'hFFFF, 3'b111, "R9 idle no effect");
    drive(1, 3'd0, 0, 16'h0080, 16'h0080, 3'b000, "R8 no flags selected");
    drive(1, 3'd0, 0, 16'hAB01, 16'hCD02, 3'b111, "R1 upper operand bits ignored");
    drive(1, 3'd2, 1, 16'h0000, 16'h0001, 3'b111, "R2 R5 word borrow");
    drive(1, 3'd3, 1, 16'h1000, 16'h0001, 3'b111, "R2 word subc carry 1");
    drive(1, 3'd1, 1, 16'hFFFF, 16'h0000, 3'b111, "R1 addc carry 0");
    drive(1, 3'd4, 0, 16'h0005, 16'h0009, 3'b011, "R3 compare less");
    drive(1, 3'd6, 0, 16'h0000, 16'h0000, 3'b100, "R7 or zero");
    drive(1, 3'd4, 1, 16'h0100, 16'h0001, 3'b010, "R6 R8 compare aux only");
    drive(0, 3'd0, 0, 16'h0000, 16'h0000, 3'b000, "R9 final idle");
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule